// File: doc/BRIEF.md
# Instruction Cycle Control Sequencer

This block is the control-unit state machine of a small word-addressed processor. It walks the machine through the four classic cycles: fetch, an optional indirect operand cycle, execute, and an interrupt cycle. It owns the four transfer registers that sit between the processor and memory: program counter, memory address, memory buffer and instruction. Each clock it issues exactly one micro-step. That micro-step can be a group of parallel register transfers, and it is reported on a one-hot micro-operation vector together with the memory read and write strobes.

Execution of the opcode itself belongs to an outside unit. That unit watches the instruction register and raises `exec_done` when it has finished. Memory answers each read or write strobe with `mem_rdy`, and the sequencer holds its current step until that answer arrives. At the end of execute the sequencer samples the interrupt request against the enable flag. When both are set, it saves the return PC at the address on the stack-pointer input, pulses a decrement strobe back to the stack pointer, and jumps to a fixed service address.

Top module: `icyc_seq`

## Requirements
- R1: Reset (synchronous, active high) clears PC, MAR, MBR and IR to zero and puts the sequencer in the fetch-address step, with both memory strobes low.
- R2: A fetch is three steps in order. First MAR takes PC. Then memory is read at MAR into MBR. Then IR takes MBR and PC increments by one in that same step.
- R3: The micro-operation vector `uop` has exactly one bit set every cycle. The bit positions are: 0 fetch-address, 1 fetch-read, 2 fetch-load, 3 indirect-address, 4 indirect-read, 5 indirect-load, 6 execute, 7 interrupt-save, 8 interrupt-write, 9 vector-load. `mem_rd` is high only in steps 1 and 4, and `mem_wr` is high only in step 8.
- R4: A read or write step repeats, with its strobe held high, until `mem_rdy` is sampled high.
- R5: When the fetched word has bit 15 set (indirect mode), the indirect cycle follows the fetch. MAR takes IR[11:0], memory is read there, and then IR[11:0] is replaced by the low 12 bits of that read. IR[15:12] are kept, and execute follows.
- R6: When bit 15 of the fetched word is clear, execute follows the fetch-load step directly.
- R7: Execute repeats until `exec_done` is sampled high. An interrupt request present during execute has no effect before then.
- R8: When `exec_done` is sampled high, the interrupt cycle starts only if `int_en` and `irq` are both high in that same cycle. Otherwise the next fetch starts.
- R9: In the interrupt-save step, MAR takes the `sp` input, MBR takes the zero-extended PC, and `sp_dec` is high for that one cycle only. The following write step puts MBR on `mem_wdata` at address MAR.
- R10: After the write completes, PC takes the fixed service address (default 0x040), and the next fetch reads from that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_rdy | input | 1 | Memory has completed the current read or write |
| mem_rdata | input | DW (16) | Word returned by memory on a read |
| exec_done | input | 1 | External execute unit has finished the instruction |
| irq | input | 1 | Interrupt request |
| int_en | input | 1 | Interrupt enable flag |
| sp | input | AW (12) | Address where the return PC is saved |
| uop | output | 10 | One-hot micro-operation of this cycle |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | AW (12) | Memory address (MAR) |
| mem_wdata | output | DW (16) | Memory write data (MBR) |
| sp_dec | output | 1 | Decrement strobe for the stack pointer |
| pc | output | AW (12) | Program counter |
| ir | output | DW (16) | Instruction register |

## Verification
The bench walks every path through the cycle graph under random memory wait states and random execute lengths, and forces the cases where a sequencer usually breaks. One case is an indirect word: a design that decides the branch from stale IR contents would skip the operand read or insert it after a direct instruction. Another is a request raised while interrupts are disabled, or while execute is still busy: a design that samples too early or ignores the enable would save the PC in the middle of an instruction. A reset in the middle of execute must bring PC back to zero. After an interrupt the saved word must be the already-incremented PC, and the next fetch must come from the service address; an off-by-one increment or a late vector load shows up as a wrong return value or a wrong fetch address.

// File: rtl/icyc_pkg.sv
package icyc_pkg;

    typedef enum logic [3:0] {
        ST_FADDR  = 4'd0,
        ST_FREAD  = 4'd1,
        ST_FLOAD  = 4'd2,
        ST_IADDR  = 4'd3,
        ST_IREAD  = 4'd4,
        ST_ILOAD  = 4'd5,
        ST_EXEC   = 4'd6,
        ST_ISAVE  = 4'd7,
        ST_IWRITE = 4'd8,
        ST_IVEC   = 4'd9
    } cyc_state_e;

    localparam int NUM_UOP = 10;

    typedef struct packed {
        logic mar_from_pc;
        logic mar_from_ira;
        logic mar_from_sp;
        logic mbr_from_mem;
        logic mbr_from_pc;
        logic ir_from_mbr;
        logic ira_from_mbr;
        logic pc_inc;
        logic pc_from_vec;
        logic mem_rd;
        logic mem_wr;
        logic sp_dec;
    } xfer_ctl_t;

    // Register transfers issued by one step; memory loads gated by ready.
    function automatic xfer_ctl_t step_ctl(cyc_state_e st, logic rdy);
        xfer_ctl_t c;
        c = '0;
        case (st)
            ST_FADDR:  c.mar_from_pc  = 1'b1;
            ST_FREAD:  begin
                c.mem_rd       = 1'b1;
                c.mbr_from_mem = rdy;
            end
            ST_FLOAD:  begin
                c.ir_from_mbr = 1'b1;
                c.pc_inc      = 1'b1;
            end
            ST_IADDR:  c.mar_from_ira = 1'b1;
            ST_IREAD:  begin
                c.mem_rd       = 1'b1;
                c.mbr_from_mem = rdy;
            end
            ST_ILOAD:  c.ira_from_mbr = 1'b1;
            ST_ISAVE:  begin
                c.mbr_from_pc = 1'b1;
                c.mar_from_sp = 1'b1;
                c.sp_dec      = 1'b1;
            end
            ST_IWRITE: c.mem_wr      = 1'b1;
            ST_IVEC:   c.pc_from_vec = 1'b1;
            default:   c = '0;
        endcase
        return c;
    endfunction

    function automatic logic is_mem_step(cyc_state_e st);
        return (st == ST_FREAD) || (st == ST_IREAD) || (st == ST_IWRITE);
    endfunction

endpackage

// File: rtl/icyc_fsm.sv
module icyc_fsm
    import icyc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       mem_rdy,
    input  logic       ind_bit,
    input  logic       exec_done,
    input  logic       irq,
    input  logic       int_en,
    output cyc_state_e state
);

    cyc_state_e nxt;
    logic       take_int;

    assign take_int = irq & int_en;

    always_comb begin
        nxt = state;
        case (state)
            ST_FADDR:  nxt = ST_FREAD;
            ST_FREAD:  if (mem_rdy) nxt = ST_FLOAD;
            ST_FLOAD:  nxt = ind_bit ? ST_IADDR : ST_EXEC;
            ST_IADDR:  nxt = ST_IREAD;
            ST_IREAD:  if (mem_rdy) nxt = ST_ILOAD;
            ST_ILOAD:  nxt = ST_EXEC;
            ST_EXEC:   if (exec_done) nxt = take_int ? ST_ISAVE : ST_FADDR;
            ST_ISAVE:  nxt = ST_IWRITE;
            ST_IWRITE: if (mem_rdy) nxt = ST_IVEC;
            ST_IVEC:   nxt = ST_FADDR;
            default:   nxt = ST_FADDR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_FADDR;
        else     state <= nxt;
    end

endmodule

// File: rtl/icyc_xfer_dec.sv
module icyc_xfer_dec
    import icyc_pkg::*;
(
    input  cyc_state_e           state,
    input  logic                 mem_rdy,
    output xfer_ctl_t            ctl,
    output logic [NUM_UOP-1:0]   uop
);

    assign ctl = step_ctl(state, mem_rdy);

    for (genvar k = 0; k < NUM_UOP; k++) begin : g_uop
        assign uop[k] = (state == cyc_state_e'(k));
    end

endmodule

// File: rtl/icyc_regs.sv
module icyc_regs
    import icyc_pkg::*;
#(
    parameter int             DW       = 16,
    parameter int             AW       = 12,
    parameter logic [AW-1:0]  SVC_ADDR = 12'h040
) (
    input  logic          clk,
    input  logic          rst,
    input  xfer_ctl_t     ctl,
    input  logic [DW-1:0] mem_rdata,
    input  logic [AW-1:0] sp,
    output logic [AW-1:0] pc,
    output logic [AW-1:0] mar,
    output logic [DW-1:0] mbr,
    output logic [DW-1:0] ir
);

    logic [DW-1:0] pc_word;
    assign pc_word = DW'(pc);

    always_ff @(posedge clk) begin
        if (rst) begin
            pc  <= '0;
            mar <= '0;
            mbr <= '0;
            ir  <= '0;
        end else begin
            if (ctl.mar_from_pc)       mar <= pc;
            else if (ctl.mar_from_ira) mar <= ir[AW-1:0];
            else if (ctl.mar_from_sp)  mar <= sp;

            if (ctl.mbr_from_mem)      mbr <= mem_rdata;
            else if (ctl.mbr_from_pc)  mbr <= pc_word;

            if (ctl.ir_from_mbr)       ir <= mbr;
            else if (ctl.ira_from_mbr) ir[AW-1:0] <= mbr[AW-1:0];

            if (ctl.pc_from_vec)       pc <= SVC_ADDR;
            else if (ctl.pc_inc)       pc <= pc + 1'b1;
        end
    end

endmodule

// File: rtl/icyc_seq.sv
module icyc_seq
    import icyc_pkg::*;
#(
    parameter int             DW       = 16,
    parameter int             AW       = 12,
    parameter logic [AW-1:0]  SVC_ADDR = 12'h040
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               mem_rdy,
    input  logic [DW-1:0]      mem_rdata,
    input  logic               exec_done,
    input  logic               irq,
    input  logic               int_en,
    input  logic [AW-1:0]      sp,
    output logic [NUM_UOP-1:0] uop,
    output logic               mem_rd,
    output logic               mem_wr,
    output logic [AW-1:0]      mem_addr,
    output logic [DW-1:0]      mem_wdata,
    output logic               sp_dec,
    output logic [AW-1:0]      pc,
    output logic [DW-1:0]      ir
);

    localparam int IND_POS = DW - 1;

    cyc_state_e    state;
    xfer_ctl_t     ctl;
    logic [AW-1:0] mar;
    logic [DW-1:0] mbr;

    icyc_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .mem_rdy   (mem_rdy),
        .ind_bit   (mbr[IND_POS]),
        .exec_done (exec_done),
        .irq       (irq),
        .int_en    (int_en),
        .state     (state)
    );

    icyc_xfer_dec u_dec (
        .state   (state),
        .mem_rdy (mem_rdy),
        .ctl     (ctl),
        .uop     (uop)
    );

    icyc_regs #(
        .DW       (DW),
        .AW       (AW),
        .SVC_ADDR (SVC_ADDR)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl),
        .mem_rdata (mem_rdata),
        .sp        (sp),
        .pc        (pc),
        .mar       (mar),
        .mbr       (mbr),
        .ir        (ir)
    );

    assign mem_rd    = ctl.mem_rd;
    assign mem_wr    = ctl.mem_wr;
    assign sp_dec    = ctl.sp_dec;
    assign mem_addr  = mar;
    assign mem_wdata = mbr;

endmodule

// File: rtl/icyc_chk.sv
module icyc_chk
    import icyc_pkg::*;
#(
    parameter int             AW       = 12,
    parameter logic [AW-1:0]  SVC_ADDR = 12'h040
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_UOP-1:0] uop,
    input logic               mem_rd,
    input logic               mem_wr,
    input logic               mem_rdy,
    input logic               exec_done,
    input logic               irq,
    input logic               int_en,
    input logic               sp_dec,
    input logic [AW-1:0]      pc
);

    localparam int B_FADDR  = int'(ST_FADDR);
    localparam int B_FREAD  = int'(ST_FREAD);
    localparam int B_FLOAD  = int'(ST_FLOAD);
    localparam int B_IREAD  = int'(ST_IREAD);
    localparam int B_EXEC   = int'(ST_EXEC);
    localparam int B_ISAVE  = int'(ST_ISAVE);
    localparam int B_IWRITE = int'(ST_IWRITE);
    localparam int B_IVEC   = int'(ST_IVEC);

    logic rst_q;
    always_ff @(posedge clk) rst_q <= rst;

    // R1
    always @(negedge clk) begin
        if (rst_q === 1'b1 && rst === 1'b0)
            reset_state_chk: assert (uop[B_FADDR] && pc == '0 && !mem_rd && !mem_wr);
    end

    // R3
    uop_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(uop) == 1);

    // R3
    rd_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd |-> (uop[B_FREAD] || uop[B_IREAD]));

    // R3
    wr_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> uop[B_IWRITE]);

    // R4
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && !mem_rdy) |=> ($stable(uop) && mem_rd));

    // R4
    wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_wr && !mem_rdy) |=> ($stable(uop) && mem_wr));

    // R2
    pc_inc_chk: assert property (@(posedge clk) disable iff (rst)
        uop[B_FLOAD] |=> (pc == AW'($past(pc) + 1'b1)));

    // R7
    exec_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (uop[B_EXEC] && !exec_done) |=> uop[B_EXEC]);

    // R8
    no_int_chk: assert property (@(posedge clk) disable iff (rst)
        (uop[B_EXEC] && exec_done && !(int_en && irq)) |=> uop[B_FADDR]);

    // R8
    int_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (uop[B_EXEC] && exec_done && int_en && irq) |=> uop[B_ISAVE]);

    // R9
    sp_dec_chk: assert property (@(posedge clk) disable iff (rst)
        sp_dec == uop[B_ISAVE]);

    // R10
    vec_pc_chk: assert property (@(posedge clk) disable iff (rst)
        uop[B_IVEC] |=> (pc == SVC_ADDR && uop[B_FADDR]));

endmodule

bind icyc_seq icyc_chk #(
    .AW       (AW),
    .SVC_ADDR (SVC_ADDR)
) u_icyc_chk (
    .clk       (clk),
    .rst       (rst),
    .uop       (uop),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_rdy   (mem_rdy),
    .exec_done (exec_done),
    .irq       (irq),
    .int_en    (int_en),
    .sp_dec    (sp_dec),
    .pc        (pc)
);

// File: tb/test_icyc_seq.sv
module test_icyc_seq;

    localparam int            DW  = 16;
    localparam int            AW  = 12;
    localparam logic [AW-1:0] SVC = 12'h040;

    localparam logic [9:0] U_FADDR  = 10'd1 << 0;
    localparam logic [9:0] U_FREAD  = 10'd1 << 1;
    localparam logic [9:0] U_FLOAD  = 10'd1 << 2;
    localparam logic [9:0] U_IADDR  = 10'd1 << 3;
    localparam logic [9:0] U_IREAD  = 10'd1 << 4;
    localparam logic [9:0] U_ILOAD  = 10'd1 << 5;
    localparam logic [9:0] U_EXEC   = 10'd1 << 6;
    localparam logic [9:0] U_ISAVE  = 10'd1 << 7;
    localparam logic [9:0] U_IWRITE = 10'd1 << 8;
    localparam logic [9:0] U_IVEC   = 10'd1 << 9;

    logic          clk = 1'b0;
    logic          rst;
    logic          mem_rdy;
    logic [DW-1:0] mem_rdata;
    logic          exec_done;
    logic          irq;
    logic          int_en;
    logic [AW-1:0] sp;
    logic [9:0]    uop;
    logic          mem_rd;
    logic          mem_wr;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          sp_dec;
    logic [AW-1:0] pc;
    logic [DW-1:0] ir;

    always #5 clk = ~clk;

    icyc_seq #(.DW(DW), .AW(AW), .SVC_ADDR(SVC)) i_icyc_seq (
        .clk(clk), .rst(rst), .mem_rdy(mem_rdy), .mem_rdata(mem_rdata),
        .exec_done(exec_done), .irq(irq), .int_en(int_en), .sp(sp),
        .uop(uop), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .sp_dec(sp_dec), .pc(pc), .ir(ir)
    );

    int            n_tests = 0;
    int            n_fail  = 0;
    logic [AW-1:0] exp_pc;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] eff_ir(logic [DW-1:0] w, logic [DW-1:0] d);
        return {w[DW-1:AW], d[AW-1:0]};
    endfunction

    function automatic logic [DW-1:0] saved_word(logic [AW-1:0] p);
        return DW'(p);
    endfunction

    // Entered at a negedge with a read or write step visible.
    task automatic mem_phase(input string req, input logic [9:0] step,
                             input logic [AW-1:0] addr, input int waits,
                             input logic [DW-1:0] word);
        chk(req, "mem step", 32'(uop), 32'(step));
        chk(req, "mem addr", 32'(mem_addr), 32'(addr));
        for (int k = 0; k < waits; k++) begin
            mem_rdy = 1'b0;
            mem_rdata = DW'($urandom);
            @(negedge clk);
            chk("R4", "held step", 32'(uop), 32'(step));
            chk("R4", "held strobe", 32'(mem_rd | mem_wr), 32'd1);
        end
        mem_rdy = 1'b1;
        mem_rdata = word;
        @(negedge clk);
        mem_rdy = 1'b0;
        mem_rdata = DW'($urandom);
    endtask

    // ind_mode: 0 random, 1 indirect, 2 direct
    // irq_mode: 0 random, 1 take, 2 irq with int_en low, 3 int_en with irq low
    task automatic run_instr(input int ind_mode, input int wmax, input int irq_mode);
        logic [DW-1:0] word, data;
        logic          take, fi, fe;
        int            jw;
        word = DW'($urandom);
        if (ind_mode == 1) word[DW-1] = 1'b1;
        if (ind_mode == 2) word[DW-1] = 1'b0;
        chk("R2", "fetch step", 32'(uop), 32'(U_FADDR));
        chk("R2", "pc at fetch", 32'(pc), 32'(exp_pc));
        chk("R9", "no sp_dec", 32'(sp_dec), 32'd0);
        @(negedge clk);
        mem_phase("R2", U_FREAD, exp_pc, int'($urandom_range(wmax, 0)), word);
        chk("R2", "load step", 32'(uop), 32'(U_FLOAD));
        @(negedge clk);
        chk("R2", "ir after fetch", 32'(ir), 32'(word));
        chk("R2", "pc incremented", 32'(pc), 32'(AW'(exp_pc + 1'b1)));
        exp_pc = AW'(exp_pc + 1'b1);
        if (word[DW-1]) begin
            chk("R5", "indirect addr step", 32'(uop), 32'(U_IADDR));
            @(negedge clk);
            data = DW'($urandom);
            mem_phase("R5", U_IREAD, word[AW-1:0], int'($urandom_range(wmax, 0)), data);
            chk("R5", "indirect load step", 32'(uop), 32'(U_ILOAD));
            @(negedge clk);
            chk("R5", "effective ir", 32'(ir), 32'(eff_ir(word, data)));
        end else begin
            chk("R6", "direct to execute", 32'(uop), 32'(U_EXEC));
        end
        chk("R7", "execute step", 32'(uop), 32'(U_EXEC));
        jw = int'($urandom_range(3, 0));
        for (int k = 0; k < jw; k++) begin
            exec_done = 1'b0;
            irq = 1'($urandom);
            int_en = 1'($urandom);
            @(negedge clk);
            chk("R7", "execute held", 32'(uop), 32'(U_EXEC));
        end
        case (irq_mode)
            1: begin fi = 1'b1; fe = 1'b1; end
            2: begin fi = 1'b1; fe = 1'b0; end
            3: begin fi = 1'b0; fe = 1'b1; end
            default: begin fi = ($urandom_range(3, 0) == 0); fe = 1'($urandom); end
        endcase
        take = fi & fe;
        irq = fi;
        int_en = fe;
        exec_done = 1'b1;
        @(negedge clk);
        exec_done = 1'b0;
        irq = 1'($urandom);
        int_en = 1'($urandom);
        if (take) begin
            chk("R8", "interrupt entry", 32'(uop), 32'(U_ISAVE));
            chk("R9", "sp_dec pulse", 32'(sp_dec), 32'd1);
            @(negedge clk);
            chk("R9", "sp_dec one cycle", 32'(sp_dec), 32'd0);
            chk("R9", "saved pc", 32'(mem_wdata), 32'(saved_word(exp_pc)));
            mem_phase("R9", U_IWRITE, sp, int'($urandom_range(wmax, 0)), DW'(0));
            sp = AW'(sp - 1'b1);
            chk("R10", "vector step", 32'(uop), 32'(U_IVEC));
            @(negedge clk);
            exp_pc = SVC;
            chk("R10", "pc at service", 32'(pc), 32'(SVC));
        end else begin
            chk("R8", "no interrupt", 32'(uop), 32'(U_FADDR));
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1", "reset uop", 32'(uop), 32'(U_FADDR));
        chk("R1", "reset pc", 32'(pc), 32'd0);
        chk("R1", "reset ir", 32'(ir), 32'd0);
        chk("R1", "reset strobes", 32'({mem_rd, mem_wr}), 32'd0);
        chk("R1", "reset addr", 32'(mem_addr), 32'd0);
        exp_pc = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20251));
        rst = 1'b1; mem_rdy = 1'b0; mem_rdata = '0; exec_done = 1'b0;
        irq = 1'b0; int_en = 1'b0; sp = 12'hFF0;
        @(negedge clk);
        do_reset();
        // directed corners
        run_instr(2, 0, 3);   // R6 direct, zero waits, enable without request
        run_instr(1, 3, 2);   // R5 indirect, request while disabled (R8)
        run_instr(1, 0, 1);   // R9 R10 interrupt straight after indirect
        run_instr(2, 4, 1);   // back-to-back interrupt with waits
        run_instr(2, 2, 2);
        // reset in the middle of execute (R1)
        chk("R1", "pre reset pc nonzero", 32'(pc != '0), 32'd1);
        @(negedge clk);
        mem_rdy = 1'b1;
        mem_rdata = 16'h0123;
        repeat (2) @(negedge clk);
        mem_rdy = 1'b0;
        do_reset();
        // random phase
        for (int n = 0; n < 300; n++) run_instr(0, 3, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule